// File: doc/BRIEF.md
# Bus Cycle Timing Controller

This block sequences a single bus access, one clock at a time, after a requester hands it an address, a direction and a target class. Three target classes exist. An internal module is reached with a fixed two-cycle access that drives no external strobe. A regular external device gets an address strobe and then a data strobe, and the access stays open until the device returns an active-low acknowledge. A fast-termination region gets both strobes and ends after two cycles without waiting, because its termination is produced inside the chip and not by the device.

The external acknowledge can come from a device on an unrelated clock. It passes through a two-flop synchronizer before the sequencer samples it. A regular access that gets no acknowledge is cut off after a limit of wait states set at request time. It then finishes with an error flag. The requester sees `ready` while the block is idle and a one-cycle `done` pulse, with `err` beside it, when the access ends.

In the requirements, cycle 1 is the clock period right after the rising edge at which the request is accepted, cycle 2 is the next period, and so on.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `ready`=1, `as_n`=1, `ds_n`=1, `rw_n`=1, `done`=0, `err`=0 and `int_sel`=0.
- R2: A request is taken on a rising edge where `ready`=1 and `req_valid`=1. `ready` is 0 from cycle 1 through the `done` cycle and returns to 1 in the cycle after it. `done` is high for exactly one cycle. Requests presented while `ready`=0 are ignored: `bus_addr` keeps the accepted address.
- R3: `req_kind`=2'b00 (internal): `int_sel`=1 in cycles 1 and 2, `done` in cycle 2, `as_n` and `ds_n` stay 1 throughout, and `err`=0.
- R4: `req_kind`=2'b10 (fast termination): `as_n`=0 and `ds_n`=0 in cycle 1. `done` comes in cycle 2 with both strobes at 1 and `err`=0, whatever `ack_n` does.
- R5: `req_kind`=2'b01 or 2'b11 (regular external): `as_n`=0 from cycle 1, and `ds_n`=0 from cycle 2, until the completing cycle. In that cycle both are 1. If `ack_n` is already 0 at the accepting edge, `done` comes in cycle 3 with `err`=0.
- R6: The acknowledge is synchronized by two flops. If `ack_n` falls during cycle j (j>=1) of a regular access, `done` comes in cycle j+3.
- R7: `tmo_lim`=T is captured at acceptance. If the acknowledge falls in cycle j with j<=T, the access completes without error in cycle j+3. If it falls later or never, `done` comes with `err`=1 in cycle T+3. When the acknowledge and the limit meet in the same cycle (j=T), the acknowledge wins.
- R8: In cycle 1 of any access, `bus_addr` shows the accepted address. `rw_n` is 0 during a write access and 1 during a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus timing is referenced to it |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents an access |
| req_kind | input | 2 | Target class: 00 internal, 01/11 regular external, 10 fast termination |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Access address |
| tmo_lim | input | TW (8) | Wait-state limit for a regular access |
| ack_n | input | 1 | Asynchronous active-low acknowledge from the external device |
| ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access ended by the wait-state limit (valid with done) |
| int_sel | output | 1 | Internal module selected |
| as_n | output | 1 | Active-low address strobe |
| ds_n | output | 1 | Active-low data strobe |
| rw_n | output | 1 | Direction: 0 = write |
| bus_addr | output | AW (16) | Captured access address |

## Verification
During a regular access, the arrival of the synchronized acknowledge and the expiry of the wait-state limit can fall in the same clock. The bench sets this up by dropping `ack_n` in exactly cycle T for a limit T. A correct block then completes in cycle T+3 with `err` low. The bench then repeats the access with the acknowledge one cycle later and expects `err` high in that same completion cycle. Both cases are judged against a completion cycle and error value that the scoreboard queue predicts independently.

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int AW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] tmo_lim,
  input  logic          ack_n,
  output logic          ready,
  output logic          done,
  output logic          err,
  output logic          int_sel,
  output logic          as_n,
  output logic          ds_n,
  output logic          rw_n,
  output logic [AW-1:0] bus_addr
);

  localparam logic [1:0] K_INT  = 2'b00;
  localparam logic [1:0] K_REG  = 2'b01;
  localparam logic [1:0] K_FAST = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2, S_T3} st_t;

  st_t           st;
  logic [1:0]    kind_q;
  logic          wr_q;
  logic          err_q;
  logic [TW-1:0] lim_q;
  logic [TW-1:0] wcnt;
  logic [1:0]    ack_sync;

  wire ack_seen = ack_sync[1];
  wire is_reg   = (kind_q == K_REG);
  wire is_int   = (kind_q == K_INT);
  wire is_fast  = (kind_q == K_FAST);

  always_ff @(posedge clk) begin
    if (!rst_n) ack_sync <= '0;
    else        ack_sync <= {ack_sync[0], ~ack_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= K_INT;
      wr_q     <= 1'b0;
      err_q    <= 1'b0;
      lim_q    <= '0;
      wcnt     <= '0;
      bus_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st       <= S_T1;
          kind_q   <= (req_kind == 2'b11) ? K_REG : req_kind;
          wr_q     <= req_write;
          bus_addr <= req_addr;
          lim_q    <= tmo_lim;
          err_q    <= 1'b0;
          wcnt     <= '0;
        end
        S_T1: st <= S_T2;
        S_T2: begin
          if (!is_reg)                st <= S_IDLE;
          else if (ack_seen)          st <= S_T3;
          else if (wcnt == lim_q) begin
            st    <= S_T3;
            err_q <= 1'b1;
          end else                    wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready   = (st == S_IDLE);
  assign done    = (st == S_T3) || (st == S_T2 && !is_reg);
  assign err     = (st == S_T3) && err_q;
  assign int_sel = is_int && (st == S_T1 || st == S_T2);
  assign as_n    = !((st == S_T1 && !is_int) || (st == S_T2 && is_reg));
  assign ds_n    = !((st == S_T1 && is_fast) || (st == S_T2 && is_reg));
  assign rw_n    = ready || !wr_q;

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic ready,
  input logic done,
  input logic err,
  input logic int_sel,
  input logic as_n,
  input logic ds_n
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> (!ready && !done)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (as_n && ds_n && !done && !int_sel)); // R1

  AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (as_n && ds_n)); // R3

  AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> !as_n); // R5

  AST_STROBES_OFF_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && ds_n)); // R5

  AST_ERR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R7

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
  .done(done), .err(err), .int_sel(int_sel), .as_n(as_n), .ds_n(ds_n)
);

// File: tb/bus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  tmo_lim = '0;
  logic        ack_n = 1'b1;
  logic        ready, done, err, int_sel, as_n, ds_n, rw_n;
  logic [15:0] bus_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int    exp_cyc_q[$];
  bit    exp_err_q[$];
  string exp_tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_cycle_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_write(req_write), .req_addr(req_addr), .tmo_lim(tmo_lim), .ack_n(ack_n),
    .ready(ready), .done(done), .err(err), .int_sel(int_sel), .as_n(as_n),
    .ds_n(ds_n), .rw_n(rw_n), .bus_addr(bus_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_cyc_q.size() == 0) begin
        chk(0, "R2 unexpected done", 1, 0);
      end else begin
        int e_c; bit e_e; string t;
        e_c = exp_cyc_q.pop_front();
        e_e = exp_err_q.pop_front();
        t   = exp_tag_q.pop_front();
        chk(cyc == e_c, {t, " done cycle"}, cyc, e_c);
        chk(err == e_e, {t, " err"}, err, e_e);
      end
    end
  end

  task automatic run(input logic [1:0] k, input logic w, input logic [15:0] a,
                     input logic [7:0] lim, input int ackj, input bit poke, input string tag);
    int L; bit e; int t0;
    bit isreg;
    isreg = k[0];
    if (!isreg) begin L = 1; e = 0; end
    else if (ackj == 0) begin L = 2; e = 0; end
    else if (ackj > 0 && ackj <= int'(lim)) begin L = ackj + 2; e = 0; end
    else begin L = int'(lim) + 2; e = 1; end
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_write = w; req_addr = a; tmo_lim = lim;
    if (ackj == 0) ack_n = 1'b0;
    @(posedge clk);
    #1 t0 = cyc;
    exp_cyc_q.push_back(t0 + L);
    exp_err_q.push_back(e);
    exp_tag_q.push_back(tag);
    for (int j = 1; j <= L + 1; j++) begin
      @(negedge clk);
      if (j == 1) begin
        req_valid = 1'b0;
        chk(bus_addr == a, "R8 bus_addr", bus_addr, a);
        chk(rw_n == !w, "R8 rw_n", rw_n, !w);
      end
      if (ackj == j) ack_n = 1'b0;
      chk(ready == 1'b0, "R2 ready low while busy", ready, 0);
      if (k == 2'b00) begin
        chk(int_sel == 1'b1, "R3 int_sel", int_sel, 1);
        chk(as_n && ds_n, "R3 strobes idle", {as_n, ds_n}, 3);
      end else if (k == 2'b10) begin
        if (j == 1) chk(!as_n && !ds_n, "R4 strobes in cycle 1", {as_n, ds_n}, 0);
        else        chk(as_n && ds_n, "R4 strobes at completion", {as_n, ds_n}, 3);
      end else begin
        if (j == 1)      chk(!as_n && ds_n, "R5 cycle 1 strobes", {as_n, ds_n}, 1);
        else if (j <= L) chk(!as_n && !ds_n, "R5 mid strobes", {as_n, ds_n}, 0);
        else             chk(as_n && ds_n, "R5 completion strobes", {as_n, ds_n}, 3);
      end
      if (poke && j == 2) begin
        req_valid = 1'b1; req_kind = 2'b00; req_addr = ~a;
      end
      if (poke && j == 3) begin
        chk(bus_addr == a, "R2 busy request ignored", bus_addr, a);
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(ready == 1'b1, {tag, " ready after done"}, ready, 1);
    ack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && as_n && ds_n && rw_n && !done && !err && !int_sel,
        "R1 reset outputs", {ready, as_n, ds_n, rw_n, done, err, int_sel}, 7'b1111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && as_n && ds_n && !done, "R1 after release",
        {ready, as_n, ds_n, done}, 4'b1110);

    run(2'b00, 1'b0, 16'h1234, 8'd4, -1, 0, "R3 internal read");
    run(2'b00, 1'b1, 16'h00F0, 8'd4, -1, 0, "R3 internal write");
    run(2'b10, 1'b1, 16'hA5A5, 8'd0, -1, 0, "R4 fast write no ack");
    run(2'b10, 1'b0, 16'h5A5A, 8'd0, 2,  0, "R4 fast read stray ack");
    run(2'b01, 1'b0, 16'h0101, 8'd4, 0,  0, "R5 regular no wait");
    run(2'b11, 1'b1, 16'h0303, 8'd4, 0,  0, "R5 kind 11 write");
    run(2'b01, 1'b1, 16'hBEEF, 8'd8, 2,  1, "R6 ack in cycle 2");
    run(2'b01, 1'b0, 16'hCAFE, 8'd10, 5, 0, "R6 ack in cycle 5");
    run(2'b01, 1'b0, 16'h7777, 8'd4, -1, 0, "R7 timeout no ack");
    run(2'b01, 1'b0, 16'h8888, 8'd4, 4,  0, "R7 ack meets limit");
    run(2'b01, 1'b1, 16'h9999, 8'd4, 5,  0, "R7 ack one late");
    run(2'b01, 1'b0, 16'h4444, 8'd0, -1, 0, "R7 zero limit");

    repeat (4) @(negedge clk);
    chk(exp_cyc_q.size() == 0, "R2 all completions seen", exp_cyc_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule